// File: doc/BRIEF.md
# Dual-Configuration Store Controller behind a JTAG TAP

This block adds a small set of private instructions to a standard IEEE 1149.1 test access port. The instructions manage two stored configurations, called A and B. The TAP state machine stays outside the block. Its current state arrives as single-cycle indications: Update-IR, Capture-DR, Shift-DR, entry to Run-Test/Idle and Test-Logic-Reset. The block keeps these registers:
- an instruction register;
- a 96-bit user data register;
- a 32-bit identification register;
- a 1-bit bypass register;
- behavioural models of the two configuration stores.

TDO is taken from the least significant bit of whichever data register is selected.

Configuration A holds the full 96-bit image. Configuration B holds only the 48-bit capacitor field. A program operation ORs the user register into the chosen store, so it can only set bits. A bulk erase clears a whole store. Program, erase and calibration all start on entry to Run-Test/Idle and then run on their own for a set number of clock cycles. While one runs, busy is raised. During erase and calibration a force-to-reference output is also raised. A verify operation copies a store into the user register without raising busy, and the result is then shifted out under the user-register instruction.

Top module: `dualcfg_ctrl`

## Requirements
- R1: After reset, busy_o and force_ref_o are 0 and the identification instruction is selected, so shifting 32 bits out returns the identification word.
- R2: The identification word is, from bit 31 down: a 4-bit version (default 0), part number 0x0121, the 11-bit manufacturer code 0x043, and a 1 in bit 0, which gives 0x00121087 by default.
- R3: An opcode that matches none of the configured opcodes selects a 1-bit bypass register. Capture-DR loads 0 into it, and each Shift-DR cycle passes TDI to TDO one cycle later.
- R4: Under the user-register opcode (default 0x0A), Shift-DR shifts the 96-bit user register right. TDI enters at bit 95 and TDO shows bit 0, so a word shifted in appears at TDO in order 96 shifts later.
- R5: Program-A (0x0B) on entry to Run-Test/Idle ORs the user register into store A. A bit of a store returns to 0 only through a bulk erase.
- R6: Program-B (0x0C) ORs only user bits [47:0] into store B. All other bits are discarded.
- R7: Verify-A (0x0D) and verify-B (0x0E) load the chosen store into the user register on entry to Run-Test/Idle without raising busy_o. Verify-B returns 0 in bits [95:48]. Capture-DR under the user-register opcode leaves the register unchanged.
- R8: When bit 94 of store A (the A/B select bit) is 1, verify-A loads all zeros instead of the contents of A.
- R9: Erase-A (0x10) and erase-B (0x11) clear the whole store on entry to Run-Test/Idle. force_ref_o is high throughout the erase.
- R10: busy_o rises in the cycle after the launching Run-Test/Idle entry. It stays high for exactly PROG_CYC, ERASE_CYC or CAL_CYC cycles (defaults 20, 30 and 40) for program, erase or calibration.
- R11: A Run-Test/Idle entry while busy_o is high launches nothing. The stores are left unchanged and the running window is not extended.
- R12: Calibration (0x12) raises busy_o and force_ref_o for CAL_CYC cycles and runs to completion even if Test-Logic-Reset is indicated meanwhile. Test-Logic-Reset returns the instruction to identification.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| tlr_i | input | 1 | TAP is in Test-Logic-Reset |
| update_ir_i | input | 1 | TAP Update-IR cycle; loads the instruction from ir_i |
| ir_i | input | IR_W | Instruction value shifted in by the TAP |
| capture_dr_i | input | 1 | TAP Capture-DR cycle |
| shift_dr_i | input | 1 | TAP Shift-DR cycle |
| rti_entry_i | input | 1 | TAP enters Run-Test/Idle this cycle |
| tdi_i | input | 1 | Serial test data in |
| tdo_o | output | 1 | Serial test data out, LSB of the selected register |
| busy_o | output | 1 | Program, erase or calibration in progress |
| force_ref_o | output | 1 | Outputs forced to reference level (erase or calibration) |

## Verification
The hardest situation to reach from the ports is a second launch that arrives in the middle of a running window. It needs a new instruction loaded and a Run-Test/Idle entry pulsed while busy_o is still high, and then a later verify to show that the store was not touched. The stimulus gets there by starting an erase and issuing program-A with a nonzero user register within the next two cycles. It counts every busy cycle from the launch, then reads store A back. The blocked verify-A case is reached by programming bit 94 on purpose, then erasing and reprogramming to show the contents reappear. A seeded random sequence of program, erase and verify operations, compared against bench models of both stores, covers the OR accumulation.

// File: rtl/dualcfg_pkg.sv
package dualcfg_pkg;

    typedef enum logic [3:0] {
        I_IDCODE,
        I_USER,
        I_PRG_A,
        I_PRG_B,
        I_VER_A,
        I_VER_B,
        I_ERA_A,
        I_ERA_B,
        I_CAL,
        I_BYPASS
    } instr_e;

    typedef enum logic [1:0] {
        OP_NONE,
        OP_PROG,
        OP_ERASE,
        OP_CAL
    } op_e;

endpackage

// File: rtl/dualcfg_ir.sv
module dualcfg_ir
    import dualcfg_pkg::*;
#(
    parameter int unsigned     IR_W       = 8,
    parameter logic [IR_W-1:0] OPC_IDCODE = 8'h01,
    parameter logic [IR_W-1:0] OPC_USER   = 8'h0A,
    parameter logic [IR_W-1:0] OPC_PRG_A  = 8'h0B,
    parameter logic [IR_W-1:0] OPC_PRG_B  = 8'h0C,
    parameter logic [IR_W-1:0] OPC_VER_A  = 8'h0D,
    parameter logic [IR_W-1:0] OPC_VER_B  = 8'h0E,
    parameter logic [IR_W-1:0] OPC_ERA_A  = 8'h10,
    parameter logic [IR_W-1:0] OPC_ERA_B  = 8'h11,
    parameter logic [IR_W-1:0] OPC_CAL    = 8'h12
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tlr_i,
    input  logic            update_ir_i,
    input  logic [IR_W-1:0] ir_i,
    output instr_e          instr_o
);

    typedef struct packed {
        instr_e instr;
    } ir_state_t;

    ir_state_t s_d, s_q;

    function automatic instr_e decode(input logic [IR_W-1:0] code);
        if (code == OPC_IDCODE) return I_IDCODE;
        if (code == OPC_USER)   return I_USER;
        if (code == OPC_PRG_A)  return I_PRG_A;
        if (code == OPC_PRG_B)  return I_PRG_B;
        if (code == OPC_VER_A)  return I_VER_A;
        if (code == OPC_VER_B)  return I_VER_B;
        if (code == OPC_ERA_A)  return I_ERA_A;
        if (code == OPC_ERA_B)  return I_ERA_B;
        if (code == OPC_CAL)    return I_CAL;
        return I_BYPASS;
    endfunction

    always_comb begin
        s_d = s_q;
        if (tlr_i) begin
            s_d.instr = I_IDCODE;
        end else if (update_ir_i) begin
            s_d.instr = decode(ir_i);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{instr: I_IDCODE};
        end else begin
            s_q <= s_d;
        end
    end

    assign instr_o = s_q.instr;

endmodule

// File: rtl/dualcfg_dr.sv
module dualcfg_dr
    import dualcfg_pkg::*;
#(
    parameter int unsigned      UR_W   = 96,
    parameter int unsigned      ID_W   = 32,
    parameter logic [ID_W-1:0]  ID_VAL = 32'h0012_1087
) (
    input  logic            clk,
    input  logic            rst_n,
    input  instr_e          instr_i,
    input  logic            capture_dr_i,
    input  logic            shift_dr_i,
    input  logic            tdi_i,
    input  logic            load_en_i,
    input  logic [UR_W-1:0] load_data_i,
    output logic [UR_W-1:0] user_o,
    output logic            tdo_o
);

    typedef struct packed {
        logic [UR_W-1:0] user;
        logic [ID_W-1:0] idsr;
        logic            byp;
    } dr_state_t;

    dr_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (load_en_i) begin
            s_d.user = load_data_i;
        end else begin
            case (instr_i)
                I_USER: begin
                    // capture keeps the contents so a verify result survives
                    if (shift_dr_i) s_d.user = {tdi_i, s_q.user[UR_W-1:1]};
                end
                I_IDCODE: begin
                    if (capture_dr_i)    s_d.idsr = ID_VAL;
                    else if (shift_dr_i) s_d.idsr = {tdi_i, s_q.idsr[ID_W-1:1]};
                end
                default: begin
                    if (capture_dr_i)    s_d.byp = 1'b0;
                    else if (shift_dr_i) s_d.byp = tdi_i;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{user: '0, idsr: ID_VAL, byp: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        case (instr_i)
            I_USER:   tdo_o = s_q.user[0];
            I_IDCODE: tdo_o = s_q.idsr[0];
            default:  tdo_o = s_q.byp;
        endcase
    end

    assign user_o = s_q.user;

endmodule

// File: rtl/dualcfg_seq.sv
module dualcfg_seq
    import dualcfg_pkg::*;
#(
    parameter int unsigned UR_W      = 96,
    parameter int unsigned CAP_W     = 48,
    parameter int unsigned ABSEL_BIT = 94,
    parameter int unsigned PROG_CYC  = 20,
    parameter int unsigned ERASE_CYC = 30,
    parameter int unsigned CAL_CYC   = 40
) (
    input  logic             clk,
    input  logic             rst_n,
    input  instr_e           instr_i,
    input  logic             rti_entry_i,
    input  logic [UR_W-1:0]  user_i,
    output logic             load_en_o,
    output logic [UR_W-1:0]  load_data_o,
    output logic             busy_o,
    output logic             force_ref_o,
    output logic [UR_W-1:0]  store_a_o,
    output logic [CAP_W-1:0] store_b_o
);

    localparam int unsigned MAX_PE  = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
    localparam int unsigned MAX_CYC = (MAX_PE > CAL_CYC) ? MAX_PE : CAL_CYC;
    localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1);

    typedef struct packed {
        logic [UR_W-1:0]  store_a;
        logic [CAP_W-1:0] store_b;
        logic [CNT_W-1:0] cnt;
        op_e              op;
    } seq_state_t;

    seq_state_t s_d, s_q;
    logic       idle;
    logic       absel;

    assign idle  = (s_q.cnt == '0);
    assign absel = s_q.store_a[ABSEL_BIT];

    always_comb begin
        s_d = s_q;
        if (!idle) begin
            s_d.cnt = s_q.cnt - CNT_W'(1);
            if (s_q.cnt == CNT_W'(1)) s_d.op = OP_NONE;
        end
        if (rti_entry_i && idle) begin
            case (instr_i)
                I_PRG_A: begin
                    s_d.store_a = s_q.store_a | user_i;
                    s_d.cnt     = CNT_W'(PROG_CYC);
                    s_d.op      = OP_PROG;
                end
                I_PRG_B: begin
                    s_d.store_b = s_q.store_b | user_i[CAP_W-1:0];
                    s_d.cnt     = CNT_W'(PROG_CYC);
                    s_d.op      = OP_PROG;
                end
                I_ERA_A: begin
                    s_d.store_a = '0;
                    s_d.cnt     = CNT_W'(ERASE_CYC);
                    s_d.op      = OP_ERASE;
                end
                I_ERA_B: begin
                    s_d.store_b = '0;
                    s_d.cnt     = CNT_W'(ERASE_CYC);
                    s_d.op      = OP_ERASE;
                end
                I_CAL: begin
                    s_d.cnt = CNT_W'(CAL_CYC);
                    s_d.op  = OP_CAL;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{store_a: '0, store_b: '0, cnt: '0, op: OP_NONE};
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        load_en_o   = rti_entry_i && idle &&
                      ((instr_i == I_VER_A) || (instr_i == I_VER_B));
        load_data_o = '0;
        if (instr_i == I_VER_A) begin
            if (!absel) load_data_o = s_q.store_a;
        end else begin
            load_data_o = {{(UR_W-CAP_W){1'b0}}, s_q.store_b};
        end
    end

    assign busy_o      = !idle;
    assign force_ref_o = !idle && ((s_q.op == OP_ERASE) || (s_q.op == OP_CAL));
    assign store_a_o   = s_q.store_a;
    assign store_b_o   = s_q.store_b;

endmodule

// File: rtl/dualcfg_ctrl.sv
module dualcfg_ctrl
    import dualcfg_pkg::*;
#(
    parameter int unsigned     IR_W       = 8,
    parameter int unsigned     UR_W       = 96,
    parameter int unsigned     CAP_W      = 48,
    parameter int unsigned     ABSEL_BIT  = 94,
    parameter int unsigned     PROG_CYC   = 20,
    parameter int unsigned     ERASE_CYC  = 30,
    parameter int unsigned     CAL_CYC    = 40,
    parameter logic [3:0]      VERSION    = 4'h0,
    parameter logic [15:0]     PART_NUM   = 16'h0121,
    parameter logic [10:0]     MFR_CODE   = 11'h043,
    parameter logic [IR_W-1:0] OPC_IDCODE = 8'h01,
    parameter logic [IR_W-1:0] OPC_USER   = 8'h0A,
    parameter logic [IR_W-1:0] OPC_PRG_A  = 8'h0B,
    parameter logic [IR_W-1:0] OPC_PRG_B  = 8'h0C,
    parameter logic [IR_W-1:0] OPC_VER_A  = 8'h0D,
    parameter logic [IR_W-1:0] OPC_VER_B  = 8'h0E,
    parameter logic [IR_W-1:0] OPC_ERA_A  = 8'h10,
    parameter logic [IR_W-1:0] OPC_ERA_B  = 8'h11,
    parameter logic [IR_W-1:0] OPC_CAL    = 8'h12
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tlr_i,
    input  logic            update_ir_i,
    input  logic [IR_W-1:0] ir_i,
    input  logic            capture_dr_i,
    input  logic            shift_dr_i,
    input  logic            rti_entry_i,
    input  logic            tdi_i,
    output logic            tdo_o,
    output logic            busy_o,
    output logic            force_ref_o
);

    localparam int unsigned ID_W   = 32;
    localparam logic [ID_W-1:0] ID_VAL = {VERSION, PART_NUM, MFR_CODE, 1'b1};

    instr_e           instr_w;
    logic             load_en_w;
    logic [UR_W-1:0]  load_data_w;
    logic [UR_W-1:0]  user_w;
    logic [UR_W-1:0]  store_a_w;
    logic [CAP_W-1:0] store_b_w;

    dualcfg_ir #(
        .IR_W(IR_W), .OPC_IDCODE(OPC_IDCODE), .OPC_USER(OPC_USER),
        .OPC_PRG_A(OPC_PRG_A), .OPC_PRG_B(OPC_PRG_B),
        .OPC_VER_A(OPC_VER_A), .OPC_VER_B(OPC_VER_B),
        .OPC_ERA_A(OPC_ERA_A), .OPC_ERA_B(OPC_ERA_B), .OPC_CAL(OPC_CAL)
    ) ir_u (
        .clk(clk), .rst_n(rst_n), .tlr_i(tlr_i), .update_ir_i(update_ir_i),
        .ir_i(ir_i), .instr_o(instr_w)
    );

    dualcfg_dr #(.UR_W(UR_W), .ID_W(ID_W), .ID_VAL(ID_VAL)) dr_u (
        .clk(clk), .rst_n(rst_n), .instr_i(instr_w),
        .capture_dr_i(capture_dr_i), .shift_dr_i(shift_dr_i), .tdi_i(tdi_i),
        .load_en_i(load_en_w), .load_data_i(load_data_w),
        .user_o(user_w), .tdo_o(tdo_o)
    );

    dualcfg_seq #(
        .UR_W(UR_W), .CAP_W(CAP_W), .ABSEL_BIT(ABSEL_BIT),
        .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC), .CAL_CYC(CAL_CYC)
    ) seq_u (
        .clk(clk), .rst_n(rst_n), .instr_i(instr_w), .rti_entry_i(rti_entry_i),
        .user_i(user_w), .load_en_o(load_en_w), .load_data_o(load_data_w),
        .busy_o(busy_o), .force_ref_o(force_ref_o),
        .store_a_o(store_a_w), .store_b_o(store_b_w)
    );

endmodule

// File: rtl/dualcfg_chk.sv
module dualcfg_chk #(
    parameter int unsigned UR_W  = 96,
    parameter int unsigned CAP_W = 48
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rti_entry_i,
    input logic             busy_o,
    input logic             force_ref_o,
    input logic [UR_W-1:0]  store_a,
    input logic [CAP_W-1:0] store_b
);

    // R10
    busy_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(rti_entry_i));

    // R9
    force_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        force_ref_o |-> busy_o);

    // R11
    no_launch_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rti_entry_i && busy_o) |=> ((store_a == $past(store_a)) && (store_b == $past(store_b))));

    // R5
    set_only_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(store_a) & ~store_a) != '0) |-> force_ref_o);

    // R6
    set_only_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(store_b) & ~store_b) != '0) |-> force_ref_o);

endmodule

bind dualcfg_ctrl dualcfg_chk #(.UR_W(UR_W), .CAP_W(CAP_W)) chk_u (
    .clk(clk), .rst_n(rst_n), .rti_entry_i(rti_entry_i), .busy_o(busy_o),
    .force_ref_o(force_ref_o), .store_a(store_a_w), .store_b(store_b_w)
);

// File: tb/dualcfg_ctrl_test.sv
module dualcfg_ctrl_test;

    localparam int unsigned PROG_CYC  = 20;
    localparam int unsigned ERASE_CYC = 30;
    localparam int unsigned CAL_CYC   = 40;
    localparam logic [7:0] OPC_IDCODE = 8'h01, OPC_USER = 8'h0A, OPC_PRG_A = 8'h0B,
                           OPC_PRG_B = 8'h0C, OPC_VER_A = 8'h0D, OPC_VER_B = 8'h0E,
                           OPC_ERA_A = 8'h10, OPC_ERA_B = 8'h11, OPC_CAL = 8'h12;

    logic clk = 1'b0, rst_n = 1'b0, tlr_i = 1'b0, update_ir_i = 1'b0;
    logic [7:0] ir_i = '0;
    logic capture_dr_i = 1'b0, shift_dr_i = 1'b0, rti_entry_i = 1'b0, tdi_i = 1'b0;
    logic tdo_o, busy_o, force_ref_o;

    int checks = 0, fails = 0;
    logic [95:0] mdl_a = '0;
    logic [47:0] mdl_b = '0;

    always #10 clk = ~clk;

    dualcfg_ctrl #(.PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC), .CAL_CYC(CAL_CYC)) uut (
        .clk(clk), .rst_n(rst_n), .tlr_i(tlr_i), .update_ir_i(update_ir_i), .ir_i(ir_i),
        .capture_dr_i(capture_dr_i), .shift_dr_i(shift_dr_i), .rti_entry_i(rti_entry_i),
        .tdi_i(tdi_i), .tdo_o(tdo_o), .busy_o(busy_o), .force_ref_o(force_ref_o)
    );

    function automatic logic [31:0] exp_id();
        return {4'h0, 16'h0121, 11'b000_0100_0011, 1'b1};
    endfunction

    function automatic logic [95:0] exp_ver_a(input logic [95:0] a);
        return a[94] ? 96'h0 : a;
    endfunction

    function automatic logic [95:0] exp_ver_b(input logic [47:0] b);
        return {48'h0, b};
    endfunction

    task automatic check(input bit ok, input string tag, input logic [95:0] act, input logic [95:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic load_ir(input logic [7:0] op);
        ir_i = op; update_ir_i = 1'b1;
        @(negedge clk);
        update_ir_i = 1'b0;
    endtask

    task automatic capture();
        capture_dr_i = 1'b1;
        @(negedge clk);
        capture_dr_i = 1'b0;
    endtask

    task automatic rti();
        rti_entry_i = 1'b1;
        @(negedge clk);
        rti_entry_i = 1'b0;
    endtask

    task automatic shift(input int n, input logic [95:0] din, output logic [95:0] dout);
        dout = '0;
        for (int i = 0; i < n; i++) begin
            tdi_i = din[i]; shift_dr_i = 1'b1;
            dout[i] = tdo_o;
            @(negedge clk);
        end
        shift_dr_i = 1'b0;
    endtask

    task automatic write_user(input logic [95:0] d);
        logic [95:0] junk;
        load_ir(OPC_USER);
        shift(96, d, junk);
    endtask

    task automatic busy_count(output int n);
        n = 0;
        while (busy_o) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic run_op(input logic [7:0] op, input int cyc);
        int n;
        load_ir(op);
        rti();
        busy_count(n);
        check(n == cyc, "R10 busy window", 96'(n), 96'(cyc));
    endtask

    task automatic read_cfg(input logic [7:0] op, output logic [95:0] got);
        load_ir(op);
        rti();
        check(busy_o == 1'b0, "R7 verify raises no busy", 96'(busy_o), 96'h0);
        load_ir(OPC_USER);
        shift(96, 96'h0, got);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [95:0] got, d;
        int n;
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check(busy_o == 1'b0, "R1 busy after reset", 96'(busy_o), 96'h0);
        check(force_ref_o == 1'b0, "R1 force after reset", 96'(force_ref_o), 96'h0);
        shift(32, 96'h0, got);
        check(got[31:0] == exp_id(), "R1 id selected after reset", got, 96'(exp_id()));

        // R2: capture then shift identification word
        capture();
        shift(32, 96'h0, got);
        check(got[31:0] == 32'h0012_1087, "R2 id word", got, 96'h0012_1087);

        // R3: unknown opcode -> bypass
        load_ir(8'hA5);
        capture();
        shift(8, 96'hB2, got);
        check(got[7:0] == {8'hB2 << 1}, "R3 bypass delay", got, 96'(8'hB2 << 1));

        // R4 and R13-style capture hold (R7)
        d = {$urandom(), $urandom(), $urandom()};
        write_user(d);
        capture();
        shift(96, 96'h0, got);
        check(got == d, "R4 user shift through", got, d);
        check(got == d, "R7 capture keeps user register", got, d);

        // R5: program A twice, OR accumulation
        d = {$urandom(), $urandom(), $urandom()}; d[94] = 1'b0;
        write_user(d);
        run_op(OPC_PRG_A, PROG_CYC);
        mdl_a |= d;
        d = {$urandom(), $urandom(), $urandom()}; d[94] = 1'b0;
        write_user(d);
        run_op(OPC_PRG_A, PROG_CYC);
        mdl_a |= d;
        read_cfg(OPC_VER_A, got);
        check(got == exp_ver_a(mdl_a), "R5 program A ORs", got, exp_ver_a(mdl_a));

        // R6: program B keeps only low field
        d = {$urandom(), $urandom(), $urandom()};
        write_user(d);
        run_op(OPC_PRG_B, PROG_CYC);
        mdl_b |= d[47:0];
        read_cfg(OPC_VER_B, got);
        check(got == exp_ver_b(mdl_b), "R6 program B field", got, exp_ver_b(mdl_b));

        // R9: erase B with forced outputs
        load_ir(OPC_ERA_B);
        rti();
        check(force_ref_o == 1'b1, "R9 force during erase", 96'(force_ref_o), 96'h1);
        busy_count(n);
        check(n == ERASE_CYC, "R10 erase window", 96'(n), 96'(ERASE_CYC));
        mdl_b = '0;
        read_cfg(OPC_VER_B, got);
        check(got == 96'h0, "R9 erase B clears", got, 96'h0);

        // R8: A/B select bit blocks verify A
        d = 96'h0; d[94] = 1'b1; d[3:0] = 4'h9;
        write_user(d);
        run_op(OPC_PRG_A, PROG_CYC);
        mdl_a |= d;
        read_cfg(OPC_VER_A, got);
        check(got == 96'h0, "R8 verify A blocked", got, 96'h0);
        run_op(OPC_ERA_A, ERASE_CYC);
        mdl_a = '0;
        d = 96'h5A5A; write_user(d);
        run_op(OPC_PRG_A, PROG_CYC);
        mdl_a |= d;
        read_cfg(OPC_VER_A, got);
        check(got == 96'h5A5A, "R8 verify A after clearing select bit", got, 96'h5A5A);

        // R11: launch during busy ignored
        write_user({32'hFFFF_0000, 64'h1234_5678_9ABC_DEF0});
        load_ir(OPC_ERA_A);
        rti();
        load_ir(OPC_PRG_A);
        rti();
        busy_count(n);
        n += 2;
        check(n == ERASE_CYC, "R11 window not extended", 96'(n), 96'(ERASE_CYC));
        mdl_a = '0;
        read_cfg(OPC_VER_A, got);
        check(got == 96'h0, "R11 program ignored while busy", got, 96'h0);

        // R12: calibration survives test-logic-reset
        load_ir(OPC_CAL);
        rti();
        check(force_ref_o == 1'b1, "R12 force during calibration", 96'(force_ref_o), 96'h1);
        tlr_i = 1'b1;
        @(negedge clk);
        tlr_i = 1'b0;
        busy_count(n);
        n += 1;
        check(n == CAL_CYC, "R12 calibration completes", 96'(n), 96'(CAL_CYC));
        capture();
        shift(32, 96'h0, got);
        check(got[31:0] == exp_id(), "R12 reset selects id", got, 96'(exp_id()));

        // random mix
        for (int it = 0; it < 40; it++) begin
            int unsigned sel;
            sel = $urandom_range(5, 0);
            d = {$urandom(), $urandom(), $urandom()};
            if ($urandom_range(7, 0) != 0) d[94] = 1'b0;
            case (sel)
                0: begin write_user(d); run_op(OPC_PRG_A, PROG_CYC); mdl_a |= d; end
                1: begin write_user(d); run_op(OPC_PRG_B, PROG_CYC); mdl_b |= d[47:0]; end
                2: begin run_op(OPC_ERA_A, ERASE_CYC); mdl_a = '0; end
                3: begin run_op(OPC_ERA_B, ERASE_CYC); mdl_b = '0; end
                4: begin
                    read_cfg(OPC_VER_A, got);
                    check(got == exp_ver_a(mdl_a), "R7 R8 random verify A", got, exp_ver_a(mdl_a));
                end
                default: begin
                    read_cfg(OPC_VER_B, got);
                    check(got == exp_ver_b(mdl_b), "R6 R7 random verify B", got, exp_ver_b(mdl_b));
                end
            endcase
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule